// File: doc/BRIEF.md
# Mailbox and Doorbell Interrupt Controller

This block sits on the bridge side between a host bus and a local bus. It merges several interrupt causes into two outputs: one interrupt toward the host and one toward the local processor. The causes are:

- writes to the low mailboxes;
- two doorbell registers, one for each direction;
- abort events;
- a level interrupt coming from the local side;
- the completion levels of two DMA channels.

Every cause has its own enable. Each output also has one global gate. Each DMA channel's completion can be steered to either output by a routing bit.

Software reaches the block through a simple single-cycle register bus. A side flag on each write tells whether the writer is the host or the local side. The flag matters for two things. Doorbells are set by the sender and cleared by the receiver, and only host writes mark mailbox flags.

A retry watchdog counts back-to-back master retries. When the run reaches a parameterized limit, it raises an abort pulse and a sticky flag. A dedicated control bit drives the system-error output.

Top module: `mdic_top`

## Requirements
- R1: After reset, every mailbox, both doorbells, all enables and all flags read 0, and `host_irq_o`, `local_irq_o`, `retry_abort_o` and `serr_o` are 0. Reset is asserted asynchronously and released through a two-flop synchronizer.
- R2: Word addresses 0 to 7 are eight 32-bit mailboxes. Either side may write them, and a read returns the last value written.
- R3: A host write to mailbox n, for n from 0 to 3, sets sticky flag bit 28+n of the control/status word (address 10). Local writes and writes to mailboxes 4 to 7 set no flag. Writing 1 to a flag bit clears it.
- R4: When the mailbox enable (bit 10) and the local output enable (bit 4) are both set, any set mailbox flag drives `local_irq_o`.
- R5: The host-to-local doorbell (address 8) works as follows. A host write ORs the data in, and a local write clears the bits written as 1. While it is nonzero, status bit 19 reads 1 and, with bit 5 and bit 4 set, `local_irq_o` is 1.
- R6: The local-to-host doorbell (address 9) works as follows. A local write ORs the data in, and a host write clears the bits written as 1. While it is nonzero, status bit 16 reads 1.
- R7: `host_irq_o` is 1 only while the global host enable (bit 0) is set and at least one enabled host cause is active. The host causes are: the local-to-host doorbell with bit 1; any abort flag with bit 2; `local_irq_i` with bit 3; a DMA channel routed to the host.
- R8: `local_irq_o` is 1 only while the local output enable (bit 4) is set and at least one enabled local cause is active. The local causes are: the host-to-local doorbell, a DMA channel routed to local, and a mailbox flag.
- R9: DMA channel k (k = 0, 1) is enabled by bit 6+k and routed by bit 8+k. Route 1 sends its done level to `host_irq_o`; route 0 sends it to `local_irq_o`.
- R10: A single-cycle pulse sets a sticky flag. `dm_abort_i` sets bit 24, `dma0_abort_i` sets bit 25 and `dma1_abort_i` sets bit 26. Each flag clears when 1 is written to it, and a set in the same cycle wins over the clear. Any set abort flag shows as status bit 17.
- R11: With the retry enable (bit 11) set, RETRY_LIMIT consecutive cycles with `retry_i` high produce one `retry_abort_o` pulse the next cycle and set flag bit 27. An `xfer_done_i` pulse restarts the count. With bit 11 clear, retries never abort.
- R12: `serr_o` follows control bit 12.
- R13: Status bits 16 to 21 are read-only. They show the local-to-host doorbell, any abort, `local_irq_i`, the host-to-local doorbell, DMA 0 done and DMA 1 done. Writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_host | input | 1 | 1: the writer is the host, 0: the writer is the local side |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| dm_abort_i | input | 1 | Direct-master abort pulse |
| dma0_abort_i | input | 1 | DMA 0 abort pulse |
| dma1_abort_i | input | 1 | DMA 1 abort pulse |
| retry_i | input | 1 | Master retry this cycle |
| xfer_done_i | input | 1 | Non-retry completion pulse |
| dma0_done_i | input | 1 | DMA 0 done level |
| dma1_done_i | input | 1 | DMA 1 done level |
| local_irq_i | input | 1 | Local interrupt request level |
| host_irq_o | output | 1 | Host interrupt |
| local_irq_o | output | 1 | Local interrupt |
| retry_abort_o | output | 1 | One-cycle abort pulse from the retry watchdog |
| serr_o | output | 1 | System error output |

## Verification
The bench builds the block with its default parameters: eight mailboxes and a retry limit of 256. A run of 256 retries therefore takes only a few hundred cycles. This lets the bench probe the exact boundary: 255 retries, then a completion, then another 255 retries must not abort, while 256 in a row must. The default mailbox count covers both flagged and unflagged mailboxes. All three abort inputs and both DMA routes are driven against each output's global gate.

// File: rtl/mdic_pkg.sv
package mdic_pkg;
  // control/status word: enable bits
  localparam int B_HOST_IE    = 0;
  localparam int B_HBELL_IE   = 1;
  localparam int B_HABORT_IE  = 2;
  localparam int B_HLOCAL_IE  = 3;
  localparam int B_LOCAL_OE   = 4;
  localparam int B_LBELL_IE   = 5;
  localparam int B_DMA0_IE    = 6;
  localparam int B_DMA1_IE    = 7;
  localparam int B_DMA0_ROUTE = 8;
  localparam int B_DMA1_ROUTE = 9;
  localparam int B_MBX_IE     = 10;
  localparam int B_RETRY_EN   = 11;
  localparam int B_SERR_FORCE = 12;
  localparam int CTRL_W       = 13;
  // sticky flags occupy the top byte: 4 aborts then 4 mailbox flags
  localparam int FLAG_LSB     = 24;
  localparam int FLAG_W       = 8;
  localparam int NUM_FLAG_MBX = 4;
  localparam int STAT_LSB     = 16;
  localparam int STAT_W       = 6;

  typedef struct packed {
    logic dma1_act;
    logic dma0_act;
    logic lbell_act;
    logic local_act;
    logic abort_act;
    logic hbell_act;
  } stat_t;
endpackage

// File: rtl/mdic_mbx_bank.sv
module mdic_mbx_bank #(
  parameter int NUM    = 8,
  parameter int FLAG_N = 4,
  parameter int DW     = 32,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_host,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic [FLAG_N-1:0] flag_hit
);
  localparam int IW = $clog2(NUM);

  logic [DW-1:0] mbx_q [NUM];
  logic [DW-1:0] mbx_d [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_mbx
    always_comb begin
      mbx_d[g] = mbx_q[g];
      if (wr_en && (wr_addr == AW'(g))) mbx_d[g] = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mbx_q[g] <= '0;
      else        mbx_q[g] <= mbx_d[g];
    end
  end

  for (genvar f = 0; f < FLAG_N; f++) begin : g_flag
    assign flag_hit[f] = wr_en && wr_host && (wr_addr == AW'(f));
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr < AW'(NUM)) rd_data = mbx_q[rd_addr[IW-1:0]];
  end
endmodule

// File: rtl/mdic_bell.sv
module mdic_bell #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic          clr_en,
  input  logic [DW-1:0] bits,
  output logic [DW-1:0] q,
  output logic          active
);
  logic [DW-1:0] d;

  always_comb begin
    d = q;
    if (set_en)      d = q | bits;
    else if (clr_en) d = q & ~bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  assign active = |q;
endmodule

// File: rtl/mdic_retry_watch.sv
module mdic_retry_watch #(
  parameter int LIMIT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic retry,
  input  logic done,
  output logic hit,
  output logic pulse_q
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign hit    = enable && retry && !done && (cnt_q == LAST);
  assign cnt_en = !enable || done || retry;

  always_comb begin
    cnt_d = cnt_q;
    if (!enable || done) cnt_d = '0;
    else if (retry)      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= hit;
  end
endmodule

// File: rtl/mdic_irq_combine.sv
module mdic_irq_combine
  import mdic_pkg::*;
(
  input  logic [CTRL_W-1:0]       ctrl,
  input  stat_t                   stat,
  input  logic [NUM_FLAG_MBX-1:0] mbx_flags,
  output logic                    host_irq,
  output logic                    local_irq
);
  logic dma0_en, dma1_en, host_src, local_src;

  assign dma0_en = ctrl[B_DMA0_IE] && stat.dma0_act;
  assign dma1_en = ctrl[B_DMA1_IE] && stat.dma1_act;

  always_comb begin
    host_src = (ctrl[B_HBELL_IE]  && stat.hbell_act)
             | (ctrl[B_HABORT_IE] && stat.abort_act)
             | (ctrl[B_HLOCAL_IE] && stat.local_act)
             | (dma0_en && ctrl[B_DMA0_ROUTE])
             | (dma1_en && ctrl[B_DMA1_ROUTE]);
    local_src = (ctrl[B_LBELL_IE] && stat.lbell_act)
              | (dma0_en && !ctrl[B_DMA0_ROUTE])
              | (dma1_en && !ctrl[B_DMA1_ROUTE])
              | (ctrl[B_MBX_IE] && (|mbx_flags));
  end

  assign host_irq  = ctrl[B_HOST_IE]  && host_src;
  assign local_irq = ctrl[B_LOCAL_OE] && local_src;
endmodule

// File: rtl/mdic_top.sv
module mdic_top
  import mdic_pkg::*;
#(
  parameter int NUM_MBX     = 8,
  parameter int AW          = 4,
  parameter int DW          = 32,
  parameter int RETRY_LIMIT = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic          bus_host,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          dm_abort_i,
  input  logic          dma0_abort_i,
  input  logic          dma1_abort_i,
  input  logic          retry_i,
  input  logic          xfer_done_i,
  input  logic          dma0_done_i,
  input  logic          dma1_done_i,
  input  logic          local_irq_i,
  output logic          host_irq_o,
  output logic          local_irq_o,
  output logic          retry_abort_o,
  output logic          serr_o
);
  localparam logic [AW-1:0] A_H2L = AW'(NUM_MBX);
  localparam logic [AW-1:0] A_L2H = AW'(NUM_MBX + 1);
  localparam logic [AW-1:0] A_CSR = AW'(NUM_MBX + 2);

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // mailboxes
  logic [DW-1:0]           mbx_rd;
  logic [NUM_FLAG_MBX-1:0] mbx_hit;
  mdic_mbx_bank #(.NUM(NUM_MBX), .FLAG_N(NUM_FLAG_MBX), .DW(DW), .AW(AW)) u_mbx (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(bus_we), .wr_host(bus_host),
    .wr_addr(bus_addr), .wr_data(bus_wdata), .rd_addr(bus_addr),
    .rd_data(mbx_rd), .flag_hit(mbx_hit)
  );

  // doorbells
  logic          h2l_we, l2h_we;
  logic [DW-1:0] h2l_q, l2h_q;
  logic          h2l_act, l2h_act;
  assign h2l_we = bus_we && (bus_addr == A_H2L);
  assign l2h_we = bus_we && (bus_addr == A_L2H);

  mdic_bell #(.DW(DW)) u_h2l (
    .clk(clk), .rst_n(rst_sync_n), .set_en(h2l_we && bus_host),
    .clr_en(h2l_we && !bus_host), .bits(bus_wdata), .q(h2l_q), .active(h2l_act)
  );
  mdic_bell #(.DW(DW)) u_l2h (
    .clk(clk), .rst_n(rst_sync_n), .set_en(l2h_we && !bus_host),
    .clr_en(l2h_we && bus_host), .bits(bus_wdata), .q(l2h_q), .active(l2h_act)
  );

  // control register
  logic              csr_we;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  assign csr_we = bus_we && (bus_addr == A_CSR);
  assign ctrl_d = bus_wdata[CTRL_W-1:0];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ctrl_q <= '0;
    else if (csr_we)  ctrl_q <= ctrl_d;
  end

  // retry watchdog
  logic retry_hit;
  mdic_retry_watch #(.LIMIT(RETRY_LIMIT)) u_retry (
    .clk(clk), .rst_n(rst_sync_n), .enable(ctrl_q[B_RETRY_EN]),
    .retry(retry_i), .done(xfer_done_i), .hit(retry_hit), .pulse_q(retry_abort_o)
  );

  // sticky flags: [3:0] aborts, [7:4] mailbox writes
  logic [FLAG_W-1:0] flag_q, flag_d, flag_set, flag_clr;
  assign flag_set = {mbx_hit, retry_hit, dma1_abort_i, dma0_abort_i, dm_abort_i};
  assign flag_clr = csr_we ? bus_wdata[FLAG_LSB +: FLAG_W] : '0;
  assign flag_d   = (flag_q & ~flag_clr) | flag_set;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) flag_q <= '0;
    else             flag_q <= flag_d;
  end

  // status and interrupt combining
  stat_t stat;
  always_comb begin
    stat.hbell_act = l2h_act;
    stat.abort_act = |flag_q[3:0];
    stat.local_act = local_irq_i;
    stat.lbell_act = h2l_act;
    stat.dma0_act  = dma0_done_i;
    stat.dma1_act  = dma1_done_i;
  end

  mdic_irq_combine u_comb (
    .ctrl(ctrl_q), .stat(stat), .mbx_flags(flag_q[7:4]),
    .host_irq(host_irq_o), .local_irq(local_irq_o)
  );

  assign serr_o = ctrl_q[B_SERR_FORCE];

  // read mux
  always_comb begin
    bus_rdata = mbx_rd;
    if (bus_addr == A_H2L)      bus_rdata = h2l_q;
    else if (bus_addr == A_L2H) bus_rdata = l2h_q;
    else if (bus_addr == A_CSR) begin
      bus_rdata = '0;
      bus_rdata[CTRL_W-1:0]             = ctrl_q;
      bus_rdata[STAT_LSB +: STAT_W]     = stat;
      bus_rdata[FLAG_LSB +: FLAG_W]     = flag_q;
    end
  end
endmodule

// File: rtl/mdic_chk.sv
module mdic_chk #(
  parameter int AW = 4,
  parameter int DW = 32,
  parameter logic [AW-1:0] A_L2H = 9,
  parameter logic [AW-1:0] A_CSR = 10
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          bus_we,
  input logic          bus_host,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [12:0]   ctrl_q,
  input logic [7:0]    flag_q,
  input logic [DW-1:0] l2h_q,
  input logic          retry_i,
  input logic          host_irq_o,
  input logic          local_irq_o,
  input logic          retry_abort_o,
  input logic          serr_o
);
  // R7
  host_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_irq_o |-> ctrl_q[0]);
  // R8
  local_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    local_irq_o |-> ctrl_q[4]);
  // R11
  retry_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    retry_abort_o |-> flag_q[3]);
  // R11
  retry_cause_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    retry_abort_o |-> $past(retry_i));
  // R3
  mbx_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && bus_host && (bus_addr < AW'(4))) |=>
      ((flag_q[7:4] & (4'b0001 << $past(bus_addr[1:0]))) != 4'b0000));
  // R6
  l2h_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && bus_host && (bus_addr == A_L2H)) |=> ((l2h_q & $past(bus_wdata)) == '0));
  // R12
  serr_rise_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(serr_o) |-> $past(bus_we && (bus_addr == A_CSR) && bus_wdata[12]));
endmodule

bind mdic_top mdic_chk #(.AW(AW), .DW(DW), .A_L2H(A_L2H), .A_CSR(A_CSR)) i_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .bus_we(bus_we), .bus_host(bus_host),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ctrl_q(ctrl_q), .flag_q(flag_q),
  .l2h_q(l2h_q), .retry_i(retry_i), .host_irq_o(host_irq_o),
  .local_irq_o(local_irq_o), .retry_abort_o(retry_abort_o), .serr_o(serr_o)
);

// File: tb/test_mdic_top.sv
module test_mdic_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_H2L = 4'd8, A_L2H = 4'd9, A_CSR = 4'd10;
  localparam logic [31:0] HOST_IE = 32'h1, HBELL_IE = 32'h2, HABORT_IE = 32'h4,
    HLOCAL_IE = 32'h8, LOCAL_OE = 32'h10, LBELL_IE = 32'h20, DMA0_IE = 32'h40,
    DMA1_IE = 32'h80, DMA0_RT = 32'h100, DMA1_RT = 32'h200, MBX_IE = 32'h400,
    RETRY_EN = 32'h800, SERR_F = 32'h1000;

  logic clk = 0, rst_n = 0;
  logic bus_we = 0, bus_host = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic dm_abort_i = 0, dma0_abort_i = 0, dma1_abort_i = 0, retry_i = 0, xfer_done_i = 0;
  logic dma0_done_i = 0, dma1_done_i = 0, local_irq_i = 0;
  logic host_irq_o, local_irq_o, retry_abort_o, serr_o;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdic_top i_mdic_top (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_host(bus_host), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dm_abort_i(dm_abort_i),
    .dma0_abort_i(dma0_abort_i), .dma1_abort_i(dma1_abort_i), .retry_i(retry_i),
    .xfer_done_i(xfer_done_i), .dma0_done_i(dma0_done_i), .dma1_done_i(dma1_done_i),
    .local_irq_i(local_irq_i), .host_irq_o(host_irq_o), .local_irq_o(local_irq_o),
    .retry_abort_o(retry_abort_o), .serr_o(serr_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic host, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_host = host; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CSR, v); check("R1 csr", v, 0);
    rd(4'd0, v);  check("R1 mbx0", v, 0);
    rd(A_H2L, v); check("R1 bell", v, 0);
    check("R1 outs", {host_irq_o, local_irq_o, retry_abort_o, serr_o}, 0);
  endtask

  task automatic t_mailbox();
    logic [31:0] v;
    for (int i = 0; i < 8; i++) wr(1'b0, 4'(i), 32'hA5000000 + 32'(i * 17));
    for (int i = 0; i < 8; i++) begin
      rd(4'(i), v); check("R2 mbx readback", v, 32'hA5000000 + 32'(i * 17));
    end
    rd(A_CSR, v); check("R3 local writes set no flag", v[31:28], 4'h0);
    wr(1'b1, 4'd2, 32'h1234);
    wr(1'b1, 4'd5, 32'h5678);
    rd(A_CSR, v); check("R3 host mbx2 flag only", v[31:28], 4'b0100);
    check("R8 no irq without enable", local_irq_o, 0);
    wr(1'b1, A_CSR, LOCAL_OE | MBX_IE);
    check("R4 mailbox local irq", local_irq_o, 1);
    check("R7 host quiet", host_irq_o, 0);
    wr(1'b1, A_CSR, LOCAL_OE | MBX_IE | 32'h4000_0000);
    rd(A_CSR, v); check("R3 flag W1C", v[31:28], 4'h0);
    check("R4 irq drops after clear", local_irq_o, 0);
    wr(1'b1, A_CSR, 0);
  endtask

  task automatic t_bells();
    logic [31:0] v;
    wr(1'b1, A_H2L, 32'h5);
    rd(A_CSR, v); check("R5 local bell status", v[19], 1);
    check("R8 gated off", local_irq_o, 0);
    wr(1'b1, A_CSR, LBELL_IE);
    check("R8 needs local_oe", local_irq_o, 0);
    wr(1'b1, A_CSR, LBELL_IE | LOCAL_OE);
    check("R5 local bell irq", local_irq_o, 1);
    wr(1'b1, A_H2L, 32'h8);
    rd(A_H2L, v); check("R5 host sets more", v, 32'hD);
    wr(1'b0, A_H2L, 32'h9);
    rd(A_H2L, v); check("R5 local W1C", v, 32'h4);
    check("R5 irq still on", local_irq_o, 1);
    wr(1'b0, A_H2L, 32'h4);
    check("R5 irq off when empty", local_irq_o, 0);
    wr(1'b0, A_L2H, 32'h80);
    rd(A_L2H, v); check("R6 local sets", v, 32'h80);
    rd(A_CSR, v); check("R6 host bell status", v[16], 1);
    wr(1'b1, A_CSR, HBELL_IE);
    check("R7 host gate off", host_irq_o, 0);
    wr(1'b1, A_CSR, HBELL_IE | HOST_IE);
    check("R7 host bell irq", host_irq_o, 1);
    wr(1'b0, A_L2H, 32'h80);
    rd(A_L2H, v); check("R6 local write does not clear", v, 32'h80);
    wr(1'b1, A_L2H, 32'h80);
    rd(A_L2H, v); check("R6 host W1C", v, 0);
    check("R7 host irq off", host_irq_o, 0);
    wr(1'b1, A_CSR, 0);
  endtask

  task automatic t_aborts();
    logic [31:0] v;
    @(negedge clk) dm_abort_i = 1; @(negedge clk) dm_abort_i = 0;
    rd(A_CSR, v); check("R10 dm abort flag", v[27:24], 4'b0001);
    check("R10 abort status", v[17], 1);
    wr(1'b1, A_CSR, HOST_IE | HABORT_IE);
    check("R7 abort host irq", host_irq_o, 1);
    @(negedge clk) begin dma0_abort_i = 1; dma1_abort_i = 1; end
    @(negedge clk) begin dma0_abort_i = 0; dma1_abort_i = 0; end
    rd(A_CSR, v); check("R10 dma abort flags", v[27:24], 4'b0111);
    wr(1'b1, A_CSR, HOST_IE | HABORT_IE | 32'h0100_0000);
    rd(A_CSR, v); check("R10 W1C one flag", v[27:24], 4'b0110);
    @(negedge clk) begin bus_we = 1; bus_host = 1; bus_addr = A_CSR;
      bus_wdata = 32'h0200_0000; dma0_abort_i = 1; end
    @(negedge clk) begin bus_we = 0; dma0_abort_i = 0; end
    rd(A_CSR, v); check("R10 set wins over clear", v[25], 1);
    wr(1'b1, A_CSR, 32'h0600_0000);
    rd(A_CSR, v); check("R10 all cleared", v[27:24], 0);
  endtask

  task automatic t_dma();
    logic [31:0] v;
    dma0_done_i = 1;
    wr(1'b1, A_CSR, HOST_IE | LOCAL_OE | DMA0_IE | DMA0_RT);
    check("R9 dma0 to host", {host_irq_o, local_irq_o}, 2'b10);
    wr(1'b1, A_CSR, HOST_IE | LOCAL_OE | DMA0_IE);
    check("R9 dma0 to local", {host_irq_o, local_irq_o}, 2'b01);
    rd(A_CSR, v); check("R13 dma0 status", v[21:16], 6'b010000);
    dma0_done_i = 0; dma1_done_i = 1;
    wr(1'b1, A_CSR, HOST_IE | LOCAL_OE | DMA1_IE | DMA1_RT);
    check("R9 dma1 to host", {host_irq_o, local_irq_o}, 2'b10);
    wr(1'b1, A_CSR, HOST_IE | LOCAL_OE | DMA0_IE | DMA0_RT);
    check("R9 dma1 disabled", {host_irq_o, local_irq_o}, 2'b00);
    dma1_done_i = 0;
    wr(1'b1, A_CSR, 32'h003F_0000);
    rd(A_CSR, v); check("R13 status read-only", v, 0);
    local_irq_i = 1;
    wr(1'b1, A_CSR, HOST_IE | HLOCAL_IE);
    check("R7 local irq forwarded", host_irq_o, 1);
    rd(A_CSR, v); check("R13 local status", v[18], 1);
    local_irq_i = 0;
    #1 check("R7 forward drops", host_irq_o, 0);
    wr(1'b1, A_CSR, 0);
  endtask

  task automatic retries(input int n);
    @(negedge clk) retry_i = 1;
    repeat (n) @(negedge clk);
    retry_i = 0;
  endtask

  task automatic t_retry();
    logic [31:0] v;
    retries(300);
    rd(A_CSR, v); check("R11 disabled no abort", v[27], 0);
    wr(1'b1, A_CSR, RETRY_EN);
    retries(255);
    check("R11 255 no pulse", retry_abort_o, 0);
    @(negedge clk) xfer_done_i = 1; @(negedge clk) xfer_done_i = 0;
    retries(255);
    check("R11 restart no pulse", retry_abort_o, 0);
    rd(A_CSR, v); check("R11 restart no flag", v[27], 0);
    @(negedge clk) xfer_done_i = 1; @(negedge clk) xfer_done_i = 0;
    retries(256);
    check("R11 pulse at 256", retry_abort_o, 1);
    @(negedge clk);
    check("R11 pulse one cycle", retry_abort_o, 0);
    rd(A_CSR, v); check("R11 retry flag", v[27], 1);
    wr(1'b1, A_CSR, 32'h0800_0000);
  endtask

  task automatic t_serr();
    wr(1'b0, A_CSR, SERR_F);
    check("R12 serr on", serr_o, 1);
    wr(1'b0, A_CSR, 0);
    check("R12 serr off", serr_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_mailbox();
    t_bells();
    t_aborts();
    t_dma();
    t_retry();
    t_serr();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule